// File: doc/BRIEF.md
# MDIO Management Controller

A CPU-facing controller for the two-wire PHY management bus. Software sees two 32-bit registers: a command register (select 0) and a data register (select 1). A command word carries a PHY address, a PHY register number, a clock-range code, a read/write choice and a busy bit. When a command is accepted with busy set, the controller shifts out one complete management frame on MDC/MDIO. For a read, it captures the PHY's reply into the data register. It then clears busy. Software polls busy to learn when the result is ready.

A build parameter picks one of two command-word layouts. The layouts place the fields at different bit positions, and they encode the direction differently. In the default layout, a command written with busy clear does not start a frame. Instead it runs a short burst of MDC pulses with MDIO released. Some PHYs only finish their reset after they see MDC edges, and this burst provides them. The MDC rate is the system clock divided by a ratio that the clock-range code selects.

Every frame lasts 64 MDC periods, with MDC idle low between operations. The register interface has no back-pressure. A command write made while busy is set is dropped. Writes to the data register are always taken.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Bit 0 of the command register reads 1 from the cycle after a command is accepted until that operation finishes, and 0 otherwise.
- R2: With ALT_LAYOUT=0, the command word has these fields: PHY address in bits 15:11, register number in bits 10:6, clock-range code in bits 5:2, bit 1 = 1 for write and 0 for read, bit 0 = busy.
- R3: With ALT_LAYOUT=1, the command word has these fields: PHY address in bits 25:21, register number in bits 20:16, clock-range code in bits 11:8, operation code in bits 3:2 (01 = write, 11 = read), bit 0 = busy.
- R4: A frame, transmitted MSB first, is: 32 ones, then 01, then opcode 01 (write) or 10 (read), then the 5-bit PHY address, then the 5-bit register number, then turnaround 10 on a write, then 16 data bits.
- R5: A write frame sends the data-register value held when the command was accepted. Later writes to the data register do not alter that frame.
- R6: On a read, MDIO output enable is driven for the first 46 bits and released for the last 18. The 16 bits sampled on the final 16 MDC rising edges are in the data register by the time busy reads 0.
- R7: A command write while busy reads 1 is ignored. The command register keeps its value, and the running frame completes unchanged, with 64 MDC periods.
- R8: The MDC period in system clocks is set by the clock-range code: 0→16, 1→26, 2→42, 3→62, 4→102, 5→124, and every other code→124.
- R9: With ALT_LAYOUT=0, a command write with bit 0 clear stores the word and produces 8 MDC periods with MDIO output enable low. Busy reads 1 during the burst.
- R10: With ALT_LAYOUT=1, a command write with bit 0 clear only stores the word. No MDC edge follows, and busy stays 0.
- R11: MDIO output changes only while MDC is low. It never changes while MDC stays high.
- R12: After reset, MDC is 0, MDIO output enable is 0, busy is 0 and the data register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe, one cycle |
| csr_sel | input | 1 | Write target: 0 command, 1 data |
| csr_wdata | input | 32 | Write data |
| csr_rsel | input | 1 | Read select: 0 command, 1 data |
| csr_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit index or shift state shows up as a wrong field in the captured frame. It also shows up as a frame that is not exactly 64 (or 8) MDC rising edges long, which becomes visible at the first MDC edge after the fault. A wrong divider count shows as an MDC period other than the table value, measured between the second and third rising edge. A busy flag that is stuck, or that clears too early, is exposed by polling. Either the poll times out, or busy reads 0 before the read data has landed, or it reads 0 while MDC is still toggling. An accepted busy-time command shows as a changed command readback or a restarted frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS  = 64;
  localparam int IDX_W       = 6;
  localparam int HALF_W      = 7;
  localparam int DRIVEN_READ = 46;
  localparam int RX_FIRST    = 48;

  typedef enum logic {
    KIND_FRAME   = 1'b0,
    KIND_CLKONLY = 1'b1
  } run_kind_e;

  typedef struct packed {
    logic       go;
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regn;
    logic [3:0] crs;
  } cmd_fields_t;

  // half of the MDC period in system clocks, chosen by clock-range code
  function automatic logic [HALF_W-1:0] mdc_half(input logic [3:0] code);
    case (code)
      4'd0:    return HALF_W'(8);
      4'd1:    return HALF_W'(13);
      4'd2:    return HALF_W'(21);
      4'd3:    return HALF_W'(31);
      4'd4:    return HALF_W'(51);
      default: return HALF_W'(62);
    endcase
  endfunction

endpackage

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
  import mdio_mgmt_pkg::*;
#(
  parameter bit ALT_LAYOUT = 1'b0
) (
  input  logic [31:0]  word,
  output cmd_fields_t  fields
);

  generate
    if (ALT_LAYOUT) begin : g_alt
      logic unused_alt;
      assign unused_alt = ^{word[31:26], word[15:12], word[7:4], word[1]};
      always_comb begin
        fields.go   = word[0];
        fields.wr   = (word[3:2] == 2'b01);
        fields.phy  = word[25:21];
        fields.regn = word[20:16];
        fields.crs  = word[11:8];
      end
    end else begin : g_legacy
      logic unused_leg;
      assign unused_leg = ^word[31:16];
      always_comb begin
        fields.go   = word[0];
        fields.wr   = word[1];
        fields.phy  = word[15:11];
        fields.regn = word[10:6];
        fields.crs  = word[5:2];
      end
    end
  endgenerate

endmodule

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_p,
  output logic              fall_p
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] last_cnt;
  logic              wrap;

  assign last_cnt = half - HALF_W'(1);
  assign wrap     = run && (cnt_q == last_cnt);
  assign rise_p   = wrap && !mdc;
  assign fall_p   = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc); // R10

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int DUMMY_MDC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  run_kind_e   kind_in,
  input  logic        wr_in,
  input  logic [4:0]  phy_in,
  input  logic [4:0]  reg_in,
  input  logic [15:0] wdata_in,
  input  logic        rise_p,
  input  logic        fall_p,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done_p,
  output logic        rd_done,
  output logic [15:0] rd_data
);

  localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_CLK   = IDX_W'(DUMMY_MDC - 1);

  run_kind_e             kind_q;
  logic                  wr_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] tx_q;
  logic [15:0]           rx_q;
  logic [IDX_W-1:0]      last_idx;
  logic                  is_frame;

  assign is_frame = active && (kind_q == KIND_FRAME);
  assign last_idx = (kind_q == KIND_CLKONLY) ? LAST_CLK : LAST_FRAME;
  assign done_p   = active && fall_p && (idx_q == last_idx);
  assign rd_done  = done_p && (kind_q == KIND_FRAME) && !wr_q;
  assign rd_data  = rx_q;
  assign mdio_o   = is_frame ? tx_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe  = is_frame && (wr_q || (idx_q < IDX_W'(DRIVEN_READ)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      kind_q <= KIND_FRAME;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      tx_q   <= '1;
      rx_q   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      kind_q <= kind_in;
      wr_q   <= wr_in;
      idx_q  <= '0;
      tx_q   <= {32'hFFFF_FFFF, 2'b01, (wr_in ? 2'b01 : 2'b10), phy_in, reg_in,
                 (wr_in ? 2'b10 : 2'b00), (wr_in ? wdata_in : 16'h0000)};
    end else if (active) begin
      if (rise_p && (kind_q == KIND_FRAME) && !wr_q && (idx_q >= IDX_W'(RX_FIRST)))
        rx_q <= {rx_q[14:0], mdio_i};
      if (fall_p) begin
        if (idx_q == last_idx) begin
          active <= 1'b0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  AST_OE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> active); // R6
  AST_TX_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o)); // R11

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter bit ALT_LAYOUT = 1'b0,
  parameter int DUMMY_MDC  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic        csr_sel,
  input  logic [31:0] csr_wdata,
  input  logic        csr_rsel,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  cmd_fields_t        fld;
  logic [31:1]        cmd_q;
  logic [15:0]        data_q;
  logic [HALF_W-1:0]  half_q;
  logic               busy;
  logic               cmd_acc;
  logic               go_frame;
  logic               go_clk;
  logic               start;
  run_kind_e          kind;
  logic               rise_p;
  logic               fall_p;
  logic               done_p;
  logic               rd_done;
  logic [15:0]        rd_data;

  mdio_cmd_decode #(.ALT_LAYOUT(ALT_LAYOUT)) u_dec (
    .word   (csr_wdata),
    .fields (fld)
  );

  assign cmd_acc  = csr_we && !csr_sel && !busy;
  assign go_frame = cmd_acc && fld.go;
  assign go_clk   = cmd_acc && !fld.go && !ALT_LAYOUT;
  assign start    = go_frame || go_clk;
  assign kind     = go_frame ? KIND_FRAME : KIND_CLKONLY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      half_q <= mdc_half(4'd0);
    end else begin
      if (cmd_acc) cmd_q <= csr_wdata[31:1];
      if (start)   half_q <= mdc_half(fld.crs);
      if (rd_done)
        data_q <= rd_data;
      else if (csr_we && csr_sel)
        data_q <= csr_wdata[15:0];
    end
  end

  assign csr_rdata = csr_rsel ? {16'h0000, data_q} : {cmd_q, busy};

  mdio_clk_gen #(.HALF_W(HALF_W)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .half   (half_q),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdio_frame_engine #(.DUMMY_MDC(DUMMY_MDC)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind_in  (kind),
    .wr_in    (fld.wr),
    .phy_in   (fld.phy),
    .reg_in   (fld.regn),
    .wdata_in (data_q),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .active   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done_p   (done_p),
    .rd_done  (rd_done),
    .rd_data  (rd_data)
  );

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    go_frame |=> busy); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_p) |=> busy); // R1
  AST_IGNORE_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_sel && busy) |=> $stable(cmd_q)); // R7

endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_phy_model (
  input  logic        mdc,
  input  logic        mdio_o,
  input  logic        mdio_oe,
  input  logic [15:0] resp,
  input  int          cyc,
  output logic        mdio_i
);
  int          edges;
  int          t1;
  int          period_cyc;
  logic [63:0] cap;
  logic [63:0] oecap;

  initial begin
    mdio_i = 1'b1; edges = 0; t1 = 0; period_cyc = 0; cap = '0; oecap = '0;
  end

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe};
    if (edges == 1) t1 = cyc;
    if (edges == 2) period_cyc = cyc - t1;
    edges = edges + 1;
  end

  always @(negedge mdc) begin
    if (edges >= 48 && edges < 64) mdio_i = resp[63 - edges];
    else mdio_i = 1'b1;
  end
endmodule

module mdio_mgmt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_l = 1'b0, we_a = 1'b0, csel = 1'b0, rsel = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata_l, rdata_a;
  logic        mdc_l, mo_l, oe_l, mi_l;
  logic        mdc_a, mo_a, oe_a, mi_a;
  logic [15:0] resp_l = '0, resp_a = '0;
  int          cyc = 0;
  int          nchk = 0;
  int          nfail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_mgmt_ctrl #(.ALT_LAYOUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .csr_we(we_l), .csr_sel(csel), .csr_wdata(wd),
    .csr_rsel(rsel), .csr_rdata(rdata_l), .mdc(mdc_l), .mdio_o(mo_l),
    .mdio_oe(oe_l), .mdio_i(mi_l));

  mdio_mgmt_ctrl #(.ALT_LAYOUT(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .csr_we(we_a), .csr_sel(csel), .csr_wdata(wd),
    .csr_rsel(rsel), .csr_rdata(rdata_a), .mdc(mdc_a), .mdio_o(mo_a),
    .mdio_oe(oe_a), .mdio_i(mi_a));

  mdio_phy_model phy_l (.mdc(mdc_l), .mdio_o(mo_l), .mdio_oe(oe_l), .resp(resp_l),
                        .cyc(cyc), .mdio_i(mi_l));
  mdio_phy_model phy_a (.mdc(mdc_a), .mdio_o(mo_a), .mdio_oe(oe_a), .resp(resp_a),
                        .cyc(cyc), .mdio_i(mi_a));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit alt, input bit sel, input logic [31:0] d);
    @(negedge clk);
    we_l = !alt; we_a = alt; csel = sel; wd = d;
    @(negedge clk);
    we_l = 1'b0; we_a = 1'b0;
  endtask

  task automatic rd(input bit alt, input bit sel, output logic [31:0] d);
    rsel = sel;
    #1;
    d = alt ? rdata_a : rdata_l;
  endtask

  task automatic wait_idle(input bit alt, input string tag);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(alt, 1'b0, v);
      if (!v[0]) return;
    end
    check({tag, " busy timeout"}, 64'd1, 64'd0);
  endtask

  task automatic phy_clear(input bit alt);
    if (alt) begin phy_a.edges = 0; phy_a.cap = '0; phy_a.oecap = '0; end
    else     begin phy_l.edges = 0; phy_l.cap = '0; phy_l.oecap = '0; end
  endtask

  function automatic logic [31:0] leg_cmd(input logic [4:0] p, input logic [4:0] r,
                                          input logic [3:0] c, input bit w, input bit b);
    return {16'h0, p, r, c, w, b};
  endfunction

  function automatic logic [31:0] alt_cmd(input logic [4:0] p, input logic [4:0] r,
                                          input logic [3:0] c, input logic [1:0] op, input bit b);
    return {6'h0, p, r, 4'h0, c, 4'h0, op, 1'b0, b};
  endfunction

  function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    check("R12 mdc", 64'(mdc_l), 64'd0);
    check("R12 oe", 64'(oe_l), 64'd0);
    rd(1'b0, 1'b0, v); check("R12 busy", 64'(v[0]), 64'd0);
    rd(1'b0, 1'b1, v); check("R12 data", 64'(v), 64'd0);
  endtask

  task automatic t_leg_write;
    logic [31:0] v, c;
    c = leg_cmd(5'h13, 5'h0A, 4'd0, 1'b1, 1'b1);
    phy_clear(1'b0);
    wr(1'b0, 1'b1, 32'h0000_A5C3);
    wr(1'b0, 1'b0, c);
    rd(1'b0, 1'b0, v); check("R1 busy set", 64'(v[0]), 64'd1);
    repeat (40) @(negedge clk);
    wr(1'b0, 1'b1, 32'h0000_1234);                                   // R5
    wr(1'b0, 1'b0, leg_cmd(5'h02, 5'h03, 4'd5, 1'b0, 1'b1));        // R7
    rd(1'b0, 1'b0, v); check("R7 cmd kept", 64'(v), 64'(c));
    wait_idle(1'b0, "R1");
    check("R2 R4 R5 frame", phy_l.cap, wr_frame(5'h13, 5'h0A, 16'hA5C3));
    check("R7 edges", 64'(phy_l.edges), 64'd64);
    check("R4 oe write", phy_l.oecap, {64{1'b1}});
    check("R8 code0 period", 64'(phy_l.period_cyc), 64'd16);
    check("R1 mdc idle", 64'(mdc_l), 64'd0);
  endtask

  task automatic t_leg_read(input logic [3:0] code, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] rsp, input int per);
    logic [31:0] v;
    phy_clear(1'b0);
    resp_l = rsp;
    wr(1'b0, 1'b0, leg_cmd(p, r, code, 1'b0, 1'b1));
    wait_idle(1'b0, "R6");
    rd(1'b0, 1'b1, v); check("R6 read data", 64'(v), 64'(rsp));
    check("R4 read header", 64'(phy_l.cap[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, p, r}));
    check("R6 oe pattern", phy_l.oecap, {{46{1'b1}}, {18{1'b0}}});
    check("R8 period", 64'(phy_l.period_cyc), 64'(per));
  endtask

  task automatic t_leg_clkonly;
    logic [31:0] v;
    phy_clear(1'b0);
    wr(1'b0, 1'b0, 32'h0000_0000);
    rd(1'b0, 1'b0, v); check("R9 busy during burst", 64'(v[0]), 64'd1);
    wait_idle(1'b0, "R9");
    check("R9 edge count", 64'(phy_l.edges), 64'd8);
    check("R9 oe low", 64'(phy_l.oecap[7:0]), 64'd0);
    check("R9 period", 64'(phy_l.period_cyc), 64'd16);
  endtask

  task automatic t_alt_write;
    phy_clear(1'b1);
    wr(1'b1, 1'b1, 32'h0000_3C0F);
    wr(1'b1, 1'b0, alt_cmd(5'h0C, 5'h11, 4'd1, 2'b01, 1'b1));
    wait_idle(1'b1, "R3");
    check("R3 alt write frame", phy_a.cap, wr_frame(5'h0C, 5'h11, 16'h3C0F));
    check("R8 code1 period", 64'(phy_a.period_cyc), 64'd26);
  endtask

  task automatic t_alt_read;
    logic [31:0] v;
    phy_clear(1'b1);
    resp_a = 16'hF00D;
    wr(1'b1, 1'b0, alt_cmd(5'h07, 5'h01, 4'd1, 2'b11, 1'b1));
    wait_idle(1'b1, "R3");
    rd(1'b1, 1'b1, v); check("R3 R6 alt read data", 64'(v), 64'h0000_F00D);
    check("R3 alt read header", 64'(phy_a.cap[63:18]),
          64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'h07, 5'h01}));
  endtask

  task automatic t_alt_nobusy;
    logic [31:0] v, c;
    c = alt_cmd(5'h04, 5'h05, 4'd0, 2'b01, 1'b0);
    phy_clear(1'b1);
    wr(1'b1, 1'b0, c);
    repeat (300) @(negedge clk);
    check("R10 no mdc edges", 64'(phy_a.edges), 64'd0);
    rd(1'b1, 1'b0, v); check("R10 stored, busy 0", 64'(v), 64'(c));
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_leg_write;
    t_leg_read(4'd2, 5'h01, 5'h02, 16'h9D2F, 42);
    t_leg_read(4'd7, 5'h1F, 5'h1F, 16'h0001, 124);
    t_leg_clkonly;
    t_alt_write;
    t_alt_read;
    t_alt_nobusy;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule